// File: doc/BRIEF.md
# Card-Detect Debounce Event Generator

This block watches the active-low detect contact of a removable card socket and turns its noisy transitions into clean, single-cycle "card arrived" and "card removed" events. The raw line is first brought into the clock domain through a flop synchronizer. Each qualifying transition of the synchronized line (re)starts a one-shot hold timer whose length is set in clock cycles, nominally about 300 ms. When the timer runs out, the block looks at the line level in that cycle and emits exactly one event: arrival if the line is low, removal if it is high.

A mode input selects which transitions arm the timer. With `fallOnly` low, both directions count. With `fallOnly` high, only high-to-low transitions (insertion) count; rising transitions neither start nor restart the timer, although the level seen at expiry still decides the event type. A separate `cardPresent` output follows the synchronized line continuously, with no debounce, for software or logic that wants the raw state.

The decision is taken from the level at expiry rather than from a run of equal samples, so a burst of contact bounce of any length produces one event, issued a fixed hold time after its last qualifying transition.

Top module: `card_detect_debounce`

## Requirements
- R1: `cardPresent` is the inverse of `detectN` delayed by the synchronizer: a change applied between clock edges k and k+1 appears at `cardPresent` after edge k+2.
- R2: With `fallOnly` = 0, a single change of `detectN` applied between edges k and k+1, with no further change, produces one event visible after edge k+HOLD_CYCLES+3.
- R3: With `fallOnly` = 1, a rising change of `detectN` (low to high) neither starts the timer from idle nor restarts a running timer.
- R4: A qualifying change while the timer runs restarts it; the event is then issued HOLD_CYCLES+3 edges after the last qualifying change, and the earlier change yields no event of its own.
- R5: The event is `insertedPulse` when the synchronized line is low in the expiry cycle, and `extractedPulse` when it is high.
- R6: `insertedPulse` and `extractedPulse` are each one cycle wide, are never high together, and exactly one of them fires per expiry.
- R7: If a qualifying transition arrives in the same cycle that the timer expires, the transition wins: no event is issued and the timer restarts.
- R8: During reset both pulse outputs are low and the synchronizer holds the "absent" level (`cardPresent` low); a line held low across reset release is reported as an insertion HOLD_CYCLES+3 edges after release.
- R9: While `detectN` stays constant and no timer runs, no event is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| detectN | input | 1 | Raw active-low card-detect line, asynchronous |
| fallOnly | input | 1 | 1: only falling transitions arm the timer; 0: both directions |
| cardPresent | output | 1 | Synchronized card presence (1 = card in) |
| insertedPulse | output | 1 | One-cycle pulse: card inserted after hold time |
| extractedPulse | output | 1 | One-cycle pulse: card removed after hold time |

## Verification
The collision of interest is timer expiry and a fresh qualifying transition landing in the same cycle. The bench provokes it by sweeping the offset of a second line change across every position from one cycle after the first up to past expiry, in both modes, so exactly one offset places the second synchronized transition in the expiry cycle. In both-edge mode that offset must yield no event at the first expiry and a single removal one full hold time later; in falling-only mode the rising change cannot restart anything, so the expiry must report removal from the sampled high level.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

  // Strobes issued by the control FSM to the timing datapath
  typedef struct packed {
    logic load;   // clear the hold counter (start or restart)
    logic run;    // advance the hold counter by one
  } cdetStrobes_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_TIMING = 1'b1
  } cdetState_t;

endpackage

// File: rtl/cdet_datapath.sv
module cdet_datapath
  import cdet_pkg::*;
#(
  parameter int HOLD_CYCLES = 15_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         detectN,
  input  logic         fallOnly,
  input  cdetStrobes_t strobes,
  output logic         syncLevel,
  output logic         qualEdge,
  output logic         expired
);

  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

  // Synchronizer chain; resets to the idle-high "absent" level
  logic [SYNC_STAGES-1:0] syncChain;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= detectN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b1;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign syncLevel = syncChain[SYNC_STAGES-1];

  // Edge detection on the synchronized level
  logic prevLevel;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= syncLevel;
  end

  logic riseSeen, fallSeen;
  assign riseSeen = syncLevel & ~prevLevel;
  assign fallSeen = ~syncLevel & prevLevel;
  assign qualEdge = fallSeen | (riseSeen & ~fallOnly);

  // Hold counter
  logic [CNT_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdCnt <= '0;
    else if (strobes.load) holdCnt <= '0;
    else if (strobes.run)  holdCnt <= holdCnt + 1'b1;
  end

  assign expired = (holdCnt == LAST_CNT);

  // R4
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (holdCnt == '0));

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= LAST_CNT);

  // R3
  rise_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fallOnly && riseSeen) |-> !qualEdge);

endmodule

// File: rtl/cdet_control.sv
module cdet_control
  import cdet_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         qualEdge,
  input  logic         expired,
  input  logic         syncLevel,
  output cdetStrobes_t strobes,
  output logic         insertedPulse,
  output logic         extractedPulse
);

  cdetState_t state, nextState;
  logic fire;

  always_comb begin
    strobes   = '0;
    fire      = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (qualEdge) begin
          strobes.load = 1'b1;
          nextState    = ST_TIMING;
        end
      end
      ST_TIMING: begin
        if (qualEdge) begin
          strobes.load = 1'b1;          // a new edge always wins over expiry
        end else if (expired) begin
          fire      = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobes.run = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      insertedPulse  <= 1'b0;
      extractedPulse <= 1'b0;
    end else begin
      state          <= nextState;
      insertedPulse  <= fire & ~syncLevel;
      extractedPulse <= fire & syncLevel;
    end
  end

  // R6
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(insertedPulse && extractedPulse));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insertedPulse || extractedPulse) |=> !(insertedPulse || extractedPulse));

  // R7
  quiet_before_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(insertedPulse || extractedPulse) |-> $past(!qualEdge));

  // R5
  inserted_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(insertedPulse) |-> $past(!syncLevel));

  // R9
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !qualEdge) |=> !(insertedPulse || extractedPulse));

endmodule

// File: rtl/card_detect_debounce.sv
module card_detect_debounce
  import cdet_pkg::*;
#(
  parameter int HOLD_CYCLES = 15_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic detectN,
  input  logic fallOnly,
  output logic cardPresent,
  output logic insertedPulse,
  output logic extractedPulse
);

  cdetStrobes_t strobes;
  logic syncLevel, qualEdge, expired;

  cdet_datapath #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .detectN   (detectN),
    .fallOnly  (fallOnly),
    .strobes   (strobes),
    .syncLevel (syncLevel),
    .qualEdge  (qualEdge),
    .expired   (expired)
  );

  cdet_control uControl (
    .clk            (clk),
    .rstN           (rstN),
    .qualEdge       (qualEdge),
    .expired        (expired),
    .syncLevel      (syncLevel),
    .strobes        (strobes),
    .insertedPulse  (insertedPulse),
    .extractedPulse (extractedPulse)
  );

  assign cardPresent = ~syncLevel;

endmodule

// File: tb/sim_card_detect_debounce.sv
module sim_card_detect_debounce;

  localparam int HOLD = 8;
  localparam int LAT  = HOLD + 3;
  localparam int WIN  = 2 * HOLD + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detectN = 1'b0;
  logic fallOnly = 1'b0;
  logic cardPresent, insertedPulse, extractedPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  card_detect_debounce #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk            (clk),
    .rstN           (rstN),
    .detectN        (detectN),
    .fallOnly       (fallOnly),
    .cardPresent    (cardPresent),
    .insertedPulse  (insertedPulse),
    .extractedPulse (extractedPulse)
  );

  task automatic chk(input string tag, input string what, input logic act,
                     input logic exp, input int step);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s step %0d: actual %0b expected %0b", tag, what, step, act, exp);
    end
  endtask

  task automatic nextStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Line goes low at step 0, back high at step d (d > WIN: stays low).
  // Expected events computed from the hold latency.
  task automatic runScenario(input logic mode, input int d, input string tag);
    int tEv1, tEv2;
    logic ev1Ins;
    logic expIns, expExt, expPres;
    tEv2 = -1;
    if (mode) begin
      tEv1 = LAT;
      ev1Ins = (d > HOLD);
    end else if (d <= HOLD) begin
      tEv1 = d + LAT;
      ev1Ins = 1'b0;
    end else begin
      tEv1 = LAT;
      ev1Ins = 1'b1;
      tEv2 = d + LAT;
    end
    fallOnly = mode;
    detectN = 1'b0;
    for (int n = 1; n <= WIN; n++) begin
      nextStep();
      expIns  = (n == tEv1) && ev1Ins;
      expExt  = ((n == tEv1) && !ev1Ins) || (n == tEv2);
      expPres = (n - 2 >= 0) && (n - 2 < d);
      chk("R1", "cardPresent", cardPresent, expPres, n);
      chk(tag, "insertedPulse", insertedPulse, expIns, n);
      chk(tag, "extractedPulse", extractedPulse, expExt, n);
      chk("R6", "pulse overlap", insertedPulse & extractedPulse, 1'b0, n);
      if (n == tEv1) chk("R5", "event type", insertedPulse, ev1Ins, n);
      if (n == d) detectN = 1'b1;
    end
  endtask

  initial begin
    // R8: reset state with the line held low
    repeat (3) @(negedge clk);
    chk("R8", "insertedPulse in reset", insertedPulse, 1'b0, 0);
    chk("R8", "extractedPulse in reset", extractedPulse, 1'b0, 0);
    chk("R8", "cardPresent in reset", cardPresent, 1'b0, 0);
    rstN = 1'b1;
    for (int n = 1; n <= LAT + 3; n++) begin
      nextStep();
      chk("R8", "insertedPulse after release", insertedPulse, n == LAT, n);
      chk("R8", "extractedPulse after release", extractedPulse, 1'b0, n);
      chk("R1", "cardPresent after release", cardPresent, n >= 2, n);
    end
    // Return line high: removal reported after hold (both-edge mode)
    detectN = 1'b1;
    for (int n = 1; n <= LAT + 3; n++) begin
      nextStep();
      chk("R2", "extractedPulse single change", extractedPulse, n == LAT, n);
      chk("R2", "insertedPulse single change", insertedPulse, 1'b0, n);
    end

    // Sweep of second-change offset in both modes
    for (int m = 0; m < 2; m++) begin
      for (int d = 1; d <= HOLD + 3; d++) begin
        string tag;
        if (m == 1)          tag = "R3";
        else if (d == HOLD)  tag = "R7";
        else if (d < HOLD)   tag = "R4";
        else                 tag = "R2";
        runScenario(logic'(m), d, tag);
      end
    end

    // R9: steady line, nothing pending
    fallOnly = 1'b0;
    for (int n = 1; n <= 3 * HOLD; n++) begin
      nextStep();
      chk("R9", "insertedPulse idle", insertedPulse, 1'b0, n);
      chk("R9", "extractedPulse idle", extractedPulse, 1'b0, n);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule